// File: doc/BRIEF.md
# Dynamic Voltage Setpoint Selector

This block picks the voltage code that each of two step-down converters receives. Every converter keeps two codes: a normal code and an alternate code. In active operation the alternate code is used only while that converter's voltage-scaling request is high. In sleep and deep sleep the choice comes from two per-converter configuration bits, and scaling requests are ignored. Scaling never leaves active operation. Only the chosen setpoint moves.

The scaling request for each converter has one of two sources. The first is a GPIO pin, which passes through a two-flop synchronizer. The second is one of three shared software request bits. A per-converter routing field picks exactly one source or disables scaling for that converter. Both converters can route to the same GPIO pin, so one pin can move both at once. Software reaches the codes, the request bits and the routing fields through a plain single-cycle write port. The selected code is registered. A one-cycle strobe marks every clock in which the registered code changes.

Top module: `dvs_setpoint_sel`

## Requirements
- R1: While reset is held, each code on `vcode_o` equals DEF_NORM (8'h3C by default), and `dvs_active_o` and `vcode_upd_o` are zero.
- R2: In active mode (`mode_i` 2'b00) with no scaling request, a converter outputs its normal code.
- R3: With routing bits [1:0] = k (1..3) and bit [2] = 0, a converter follows software request bit k-1 (address 4, bits [2:0]). While that bit is 1 in active mode, the converter outputs its alternate code and raises its `dvs_active_o` bit. The other converter is unaffected.
- R4: With routing bits [2:0] = 0, scaling is disabled for that converter. Software bits and GPIO pins then have no effect on its output.
- R5: With routing bit [2] = 1, the request is GPIO pin `gpio_i[idx]`, where idx = routing bits [4:3]. Software bits are then ignored. A GPIO change shows on `vcode_o` at the third rising clock edge after the change.
- R6: In sleep (2'b01) a converter outputs its alternate code if routing bit [5] is 1, and its normal code otherwise. In deep sleep (2'b10) routing bit [6] decides in the same way. In both modes, scaling requests are ignored and `dvs_active_o` is 0.
- R7: A `vcode_upd_o` bit is 1 for exactly those cycles in which that converter's code on `vcode_o` differs from its value one cycle earlier.
- R8: Write map: address 2b holds the normal code of converter b, and address 2b+1 holds its alternate code. Address 4 holds the software request bits. Address 5+b holds the routing byte of converter b. A write sampled at edge k shows on `vcode_o` at edge k+1.
- R9: After reset, converter 0 has scaling disabled and converter 1 follows software bit 0.
- R10: Mode 2'b11 behaves as active mode.
- R11: A write to an unmapped address changes no output and no stored setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 active, 01 sleep, 10 deep sleep, 11 treated as active |
| gpio_i | input | 4 | Asynchronous GPIO request pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| vcode_o | output | 16 | Selected codes, converter 0 in bits [7:0] |
| dvs_active_o | output | 2 | Per-converter scaling active in active mode |
| vcode_upd_o | output | 2 | Per-converter one-cycle code-change strobe |

## Verification
A corrupted routing field or request bit shows as the wrong code on `vcode_o` one edge after the corruption. A corrupted stored code shows there only while that code is selected. A stuck output register shows as a strobe without a code change, or a code change without a strobe, in the very next cycle. A broken synchronizer stage shifts the GPIO response away from the third edge, and the bench samples exactly at that edge.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SLEEP  = 2'b01,
    MODE_DEEP   = 2'b10,
    MODE_RSVD   = 2'b11
  } op_mode_e;
endpackage

// File: rtl/dvs_gpio_sync.sv
module dvs_gpio_sync #(
  parameter int NGPIO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGPIO-1:0] pin_i,
  output logic [NGPIO-1:0] pin_s_o
);
  logic [NGPIO-1:0] meta_q;
  logic [NGPIO-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= pin_i;
      stab_q <= meta_q;
    end
  end

  assign pin_s_o = stab_q;
endmodule

// File: rtl/dvs_regfile.sv
module dvs_regfile #(
  parameter int NBUCK = 2,
  parameter int VW    = 8,
  parameter int NSW   = 3,
  parameter int CFGW  = 7,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter logic [VW-1:0] DEF_NORM = 8'h3C,
  parameter logic [VW-1:0] DEF_ALT  = 8'h2A,
  parameter logic [NBUCK*CFGW-1:0] DEF_CFG = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [DW-1:0]                   wr_data_i,
  output logic [NBUCK-1:0][VW-1:0]        norm_o,
  output logic [NBUCK-1:0][VW-1:0]        alt_o,
  output logic [NBUCK-1:0][CFGW-1:0]      cfg_o,
  output logic [NSW-1:0]                  sw_o
);
  localparam int A_SW  = 2 * NBUCK;
  localparam int A_CFG = A_SW + 1;

  logic [NSW-1:0] sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
    end else if (wr_en_i && wr_addr_i == AW'(A_SW)) begin
      sw_q <= wr_data_i[NSW-1:0];
    end
  end
  assign sw_o = sw_q;

  for (genvar b = 0; b < NBUCK; b++) begin : g_rail
    logic [VW-1:0]   norm_q;
    logic [VW-1:0]   alt_q;
    logic [CFGW-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        norm_q <= DEF_NORM;
        alt_q  <= DEF_ALT;
        cfg_q  <= DEF_CFG[b*CFGW +: CFGW];
      end else if (wr_en_i) begin
        if (wr_addr_i == AW'(2 * b))     norm_q <= wr_data_i[VW-1:0];
        if (wr_addr_i == AW'(2 * b + 1)) alt_q  <= wr_data_i[VW-1:0];
        if (wr_addr_i == AW'(A_CFG + b)) cfg_q  <= wr_data_i[CFGW-1:0];
      end
    end

    assign norm_o[b] = norm_q;
    assign alt_o[b]  = alt_q;
    assign cfg_o[b]  = cfg_q;
  end
endmodule

// File: rtl/dvs_rail_select.sv
module dvs_rail_select
  import dvs_pkg::*;
#(
  parameter int VW    = 8,
  parameter int NSW   = 3,
  parameter int NGPIO = 4,
  parameter int CFGW  = 7,
  parameter logic [VW-1:0] RST_CODE = 8'h3C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_mode_e         mode_i,
  input  logic [CFGW-1:0]  cfg_i,
  input  logic [NSW-1:0]   sw_i,
  input  logic [NGPIO-1:0] gpio_s_i,
  input  logic [VW-1:0]    norm_i,
  input  logic [VW-1:0]    alt_i,
  output logic [VW-1:0]    code_o,
  output logic             dvs_o,
  output logic             upd_o
);
  localparam int SELW  = $clog2(NSW + 1);
  localparam int GIDXW = $clog2(NGPIO);
  localparam int P_GEN = SELW;
  localparam int P_IDX = SELW + 1;
  localparam int P_SLP = P_IDX + GIDXW;
  localparam int P_DEP = P_SLP + 1;

  logic [SELW-1:0]  src_sel;
  logic [GIDXW-1:0] gidx;
  logic             sw_req;
  logic             gp_req;
  logic             req;
  logic             use_alt;
  logic             act_mode;
  logic [VW-1:0]    code_d;
  logic [VW-1:0]    code_q;
  logic             dvs_q;
  logic             upd_q;

  assign src_sel = cfg_i[SELW-1:0];
  assign gidx    = cfg_i[P_IDX +: GIDXW];

  always_comb begin
    sw_req = 1'b0;
    for (int i = 0; i < NSW; i++) begin
      if (src_sel == SELW'(i + 1)) sw_req = sw_i[i];
    end
  end

  always_comb begin
    gp_req = 1'b0;
    for (int i = 0; i < NGPIO; i++) begin
      if (gidx == GIDXW'(i)) gp_req = gpio_s_i[i];
    end
  end

  assign req = cfg_i[P_GEN] ? gp_req : sw_req;

  always_comb begin
    act_mode = 1'b0;
    unique case (mode_i)
      MODE_SLEEP: use_alt = cfg_i[P_SLP];
      MODE_DEEP:  use_alt = cfg_i[P_DEP];
      default: begin
        use_alt  = req;
        act_mode = 1'b1;
      end
    endcase
  end

  assign code_d = use_alt ? alt_i : norm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_CODE;
      dvs_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      dvs_q  <= act_mode & req;
      upd_q  <= (code_d != code_q);
    end
  end

  assign code_o = code_q;
  assign dvs_o  = dvs_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/dvs_setpoint_sel.sv
module dvs_setpoint_sel
  import dvs_pkg::*;
#(
  parameter int NBUCK = 2,
  parameter int VW    = 8,
  parameter int NSW   = 3,
  parameter int NGPIO = 4,
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter logic [VW-1:0] DEF_NORM = 8'h3C,
  parameter logic [VW-1:0] DEF_ALT  = 8'h2A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic [NGPIO-1:0]    gpio_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  output logic [NBUCK*VW-1:0] vcode_o,
  output logic [NBUCK-1:0]    dvs_active_o,
  output logic [NBUCK-1:0]    vcode_upd_o
);
  localparam int SELW  = $clog2(NSW + 1);
  localparam int GIDXW = $clog2(NGPIO);
  localparam int CFGW  = SELW + 1 + GIDXW + 2;

  // Default routing: rail 0 disabled, rail 1 on software bit 0.
  function automatic logic [NBUCK*CFGW-1:0] def_cfg();
    logic [NBUCK*CFGW-1:0] v;
    v = '0;
    if (NBUCK > 1) v[CFGW +: SELW] = SELW'(1);
    return v;
  endfunction
  localparam logic [NBUCK*CFGW-1:0] DEF_CFG = def_cfg();

  op_mode_e                    mode;
  logic [NGPIO-1:0]            gpio_s;
  logic [NBUCK-1:0][VW-1:0]    norm_w;
  logic [NBUCK-1:0][VW-1:0]    alt_code_w;
  logic [NBUCK-1:0][CFGW-1:0]  cfg_w;
  logic [NSW-1:0]              sw_w;

  assign mode = op_mode_e'(mode_i);

  dvs_gpio_sync #(.NGPIO(NGPIO)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (gpio_i),
    .pin_s_o (gpio_s)
  );

  dvs_regfile #(
    .NBUCK(NBUCK), .VW(VW), .NSW(NSW), .CFGW(CFGW), .AW(AW), .DW(DW),
    .DEF_NORM(DEF_NORM), .DEF_ALT(DEF_ALT), .DEF_CFG(DEF_CFG)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .norm_o    (norm_w),
    .alt_o     (alt_code_w),
    .cfg_o     (cfg_w),
    .sw_o      (sw_w)
  );

  for (genvar b = 0; b < NBUCK; b++) begin : g_sel
    dvs_rail_select #(
      .VW(VW), .NSW(NSW), .NGPIO(NGPIO), .CFGW(CFGW), .RST_CODE(DEF_NORM)
    ) u_rail (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .cfg_i    (cfg_w[b]),
      .sw_i     (sw_w),
      .gpio_s_i (gpio_s),
      .norm_i   (norm_w[b]),
      .alt_i    (alt_code_w[b]),
      .code_o   (vcode_o[b*VW +: VW]),
      .dvs_o    (dvs_active_o[b]),
      .upd_o    (vcode_upd_o[b])
    );
  end
endmodule

// File: rtl/dvs_setpoint_sel_chk.sv
module dvs_setpoint_sel_chk #(
  parameter int NBUCK = 2,
  parameter int VW    = 8,
  parameter logic [VW-1:0] DEF_NORM = 8'h3C
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode_i,
  input logic [NBUCK*VW-1:0]      vcode_o,
  input logic [NBUCK-1:0]         dvs_active_o,
  input logic [NBUCK-1:0]         vcode_upd_o,
  input logic [NBUCK-1:0][VW-1:0] alt_code
);
  for (genvar b = 0; b < NBUCK; b++) begin : g_chk
    // R7
    p_upd_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vcode_upd_o[b] == (vcode_o[b*VW +: VW] != $past(vcode_o[b*VW +: VW])));

    // R6
    p_sleep_no_dvs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01 || mode_i == 2'b10) |=> !dvs_active_o[b]);

    // R3
    p_dvs_alt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dvs_active_o[b] |-> vcode_o[b*VW +: VW] == $past(alt_code[b]));

    // R1
    always @(negedge clk) begin
      if (!rst_n) begin
        p_reset_state_r1: assert (vcode_o[b*VW +: VW] == DEF_NORM
                                  && !dvs_active_o[b] && !vcode_upd_o[b]);
      end
    end
  end
endmodule

bind dvs_setpoint_sel dvs_setpoint_sel_chk #(
  .NBUCK(NBUCK), .VW(VW), .DEF_NORM(DEF_NORM)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .vcode_o      (vcode_o),
  .dvs_active_o (dvs_active_o),
  .vcode_upd_o  (vcode_upd_o),
  .alt_code     (alt_code_w)
);

// File: tb/sim_dvs_setpoint_sel.sv
module sim_dvs_setpoint_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [3:0]  gpio_i = 4'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = 4'b0;
  logic [7:0]  wr_data_i = 8'b0;
  logic [15:0] vcode_o;
  logic [1:0]  dvs_active_o;
  logic [1:0]  vcode_upd_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dvs_setpoint_sel u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .gpio_i(gpio_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .vcode_o(vcode_o), .dvs_active_o(dvs_active_o), .vcode_upd_o(vcode_upd_o)
  );

  // fields: mode[26:25] sw[24:22] gpio[21:18] exp0[17:10] exp1[9:2] dvs[1:0]
  localparam int NV = 9;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {2'b00, 3'b000, 4'b0000, 8'h40, 8'h50, 2'b00},  // R2
    {2'b00, 3'b001, 4'b0000, 8'h40, 8'h20, 2'b10},  // R3 R5
    {2'b00, 3'b000, 4'b0100, 8'h30, 8'h50, 2'b01},  // R5
    {2'b00, 3'b001, 4'b0100, 8'h30, 8'h20, 2'b11},  // R3 R5
    {2'b00, 3'b110, 4'b1011, 8'h40, 8'h50, 2'b00},  // R3 R5
    {2'b01, 3'b001, 4'b0100, 8'h30, 8'h50, 2'b00},  // R6
    {2'b10, 3'b000, 4'b0000, 8'h40, 8'h20, 2'b00},  // R6
    {2'b11, 3'b001, 4'b0100, 8'h30, 8'h20, 2'b11},  // R10
    {2'b00, 3'b000, 4'b1011, 8'h40, 8'h50, 2'b00}   // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 code0", vcode_o[7:0], 8'h3C);
    check("R1 code1", vcode_o[15:8], 8'h3C);
    check("R1 flags", {dvs_active_o, vcode_upd_o}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9 default routing
    wr(4'd4, 8'h01);
    @(negedge clk);
    check("R9 rail0 disabled", vcode_o[7:0], 8'h3C);
    check("R9 rail1 sw0", vcode_o[15:8], 8'h2A);
    wr(4'd4, 8'h02);
    @(negedge clk);
    check("R9 rail1 ignores sw1", vcode_o[15:8], 8'h3C);

    // program codes and routing
    wr(4'd0, 8'h40); wr(4'd1, 8'h30); wr(4'd2, 8'h50); wr(4'd3, 8'h20);
    wr(4'd5, 8'h34); wr(4'd6, 8'h41);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_i = VEC[i][26:25];
      gpio_i = VEC[i][21:18];
      wr(4'd4, {5'b0, VEC[i][24:22]});
      repeat (4) @(negedge clk);
      check("R2-table code0", vcode_o[7:0], VEC[i][17:10]);
      check("R3-table code1", vcode_o[15:8], VEC[i][9:2]);
      check("R6-table dvs", dvs_active_o, VEC[i][1:0]);
    end

    // R8 write latency and R7 strobe
    mode_i = 2'b00; gpio_i = 4'b0;
    wr(4'd4, 8'h00);
    repeat (3) @(negedge clk);
    wr(4'd0, 8'h41);
    check("R8 not yet", vcode_o[7:0], 8'h40);
    @(negedge clk);
    check("R8 updated", vcode_o[7:0], 8'h41);
    check("R7 strobe", vcode_upd_o, 2'b01);
    @(negedge clk);
    check("R7 strobe one cycle", vcode_upd_o, 2'b00);

    // R5 GPIO three-edge latency
    gpio_i = 4'b0100;
    repeat (2) @(negedge clk);
    check("R5 before third edge", vcode_o[7:0], 8'h41);
    @(negedge clk);
    check("R5 at third edge", vcode_o[7:0], 8'h30);
    gpio_i = 4'b0000;
    repeat (4) @(negedge clk);

    // R4 disabled routing ignores all requests
    wr(4'd5, 8'h00);
    wr(4'd4, 8'h07);
    gpio_i = 4'b1111;
    repeat (4) @(negedge clk);
    check("R4 code0 normal", vcode_o[7:0], 8'h41);
    check("R4 dvs0 low", dvs_active_o[0], 1'b0);

    // R3 other software bit, other rail unaffected
    gpio_i = 4'b0000;
    wr(4'd6, 8'h03);
    wr(4'd4, 8'h04);
    @(negedge clk);
    check("R3 sw2 rail1 alt", vcode_o[15:8], 8'h20);
    check("R3 rail0 untouched", vcode_o[7:0], 8'h41);
    wr(4'd4, 8'h03);
    @(negedge clk);
    check("R3 sw2 low rail1 normal", vcode_o[15:8], 8'h50);

    // R11 unmapped write
    wr(4'd15, 8'hFF);
    repeat (2) @(negedge clk);
    check("R11 outputs", {vcode_o, dvs_active_o, vcode_upd_o}, {8'h50, 8'h41, 4'b0000});
    wr(4'd4, 8'h04);
    @(negedge clk);
    check("R11 settings kept", vcode_o, {8'h20, 8'h41});

    finish_run();
  end
endmodule